// File: doc/BRIEF.md
# Three-Phase Centre-Aligned PWM Generator

The block drives a three-phase inverter bridge with three complementary output pairs, one high-side and one low-side signal per phase, all active high. A triangular time base counts up from zero to a programmable half-period value and back down. Each phase compares the counter against its own duty value to form a pulse that is centred on the middle of the period. The low side is the complement of the high side. On each output the rising edge is held back by a programmable dead time, so the two switches of a leg never conduct together.

Configuration goes through a simple write port with a register select and a data word. Every write lands in a shadow copy. The shadow copies become active at the start of a period. In double update mode the duty values are also taken again at the period midpoint, so the two halves of one period can carry different duties and give asymmetric pulses. A sync pulse of programmable width marks each period start, and also each midpoint in double update mode. A status output tells which half of the period is running. When external synchronization is selected, a rising edge on an asynchronous input restarts the period.

Top module: `pwm3_gen`

## Requirements
- R1: With half-period value H, the counter runs 0,1,...,H-1 while `second_half`=0, then H,H-1,...,1 while `second_half`=1, then wraps to 0. One period is 2H cycles.
- R2: For a phase with duty D, clamped to H, the raw high-side drive is on when the counter is at or above H-D in the first half, and strictly above H-D in the second half. This gives 2D cycles centred on the midpoint. D=0 keeps it off and D>=H keeps it on.
- R3: The low side is the complement of the raw high side. Each output rises only after its raw drive has been on for the dead-time count of cycles, and falls at once. The two outputs of a pair are never high together.
- R4: Register writes go to shadow copies. They take effect at the next period start, so a write in the middle of a period does not change the rest of that period.
- R5: When mode bit 0 (double update) is set, the duty values are reloaded from the shadows at the midpoint. The second half then uses them.
- R6: At every period start, `sync_out` goes high for W cycles, where W is the sync-width register. The pulse begins in the cycle where the counter is 0. W=0 gives no pulse.
- R7: In double update mode a second pulse of W cycles begins in the cycle where the counter reaches H.
- R8: When mode bit 1 (external sync) is active, a rising edge on `ext_sync` restarts the period. The counter reads 0 and the start pulse begins three clock edges after the input rises. When the bit is clear, `ext_sync` has no effect.
- R9: A half-period value below 2 is stored as 2.
- R10: Register select codes: 0 half-period, 1 dead time, 2/3/4 duty of phase 0/1/2, 5 mode (bit 0 double update, bit 1 external sync), 6 sync width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (R10) |
| cfg_data | input | CW | Write data |
| ext_sync | input | 1 | Asynchronous external period restart |
| pwm_hi | output | 3 | High-side drives, one bit per phase |
| pwm_lo | output | 3 | Low-side drives, one bit per phase |
| sync_out | output | 1 | Period sync pulse |
| second_half | output | 1 | 1 while the counter runs down |

## Verification
On every cycle the assertions check the following: the counter stays inside the range allowed for its half; the wrap and the midpoint turn happen exactly where R1 puts them; no pair is ever high on both sides; every output that rises leaves a gap after its partner when the dead time is non-zero; and sync pulses start only at the counter's end points. The scenarios alone can show the following: the pulse widths for each duty and dead-time combination; that shadowing holds a mid-period write back; that the midpoint reload produces an asymmetric pulse; the sync pulse widths in each update mode; the three-edge latency of an external restart; and the clamping of small half-period values.

// File: rtl/pwm3_pkg.sv
// Package pwm3_pkg: register select codes and mode bit positions shared
// by the PWM generator and its bench. Assumes a 3-bit select field.
package pwm3_pkg;
    typedef enum logic [2:0] {
        SEL_HALF  = 3'd0,
        SEL_DEAD  = 3'd1,
        SEL_DUTY0 = 3'd2,
        SEL_DUTY1 = 3'd3,
        SEL_DUTY2 = 3'd4,
        SEL_MODE  = 3'd5,
        SEL_SYNCW = 3'd6
    } pwm3_sel_e;

    localparam int MODE_DBL_BIT = 0;
    localparam int MODE_EXT_BIT = 1;
endpackage

// File: rtl/pwm3_regs.sv
// pwm3_regs: shadow and active copies of all configuration.
// Writes land in the shadows. load_all copies every shadow to active,
// and load_duty copies the three duties only. Assumes CW >= DTW, SWW.
module pwm3_regs
    import pwm3_pkg::*;
#(
    parameter int CW       = 10,
    parameter int DTW      = 6,
    parameter int SWW      = 6,
    parameter int DEF_HALF = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [2:0]          sel,
    input  logic [CW-1:0]       wdata,
    input  logic                load_all,
    input  logic                load_duty,
    output logic [CW-1:0]       act_half,
    output logic [DTW-1:0]      act_dead,
    output logic [2:0][CW-1:0]  act_duty,
    output logic [1:0]          act_mode,
    output logic [SWW-1:0]      act_syncw,
    output logic [SWW-1:0]      sh_syncw
);
    localparam logic [CW-1:0] MIN_HALF = CW'(2);

    logic [CW-1:0]      sh_half;
    logic [DTW-1:0]     sh_dead;
    logic [2:0][CW-1:0] sh_duty;
    logic [1:0]         sh_mode;

    // Capture host writes into the shadow copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_half  <= CW'(DEF_HALF);
            sh_dead  <= '0;
            sh_duty  <= '0;
            sh_mode  <= '0;
            sh_syncw <= SWW'(1);
        end else if (we) begin
            case (pwm3_sel_e'(sel))
                SEL_HALF:  sh_half    <= (wdata < MIN_HALF) ? MIN_HALF : wdata;
                SEL_DEAD:  sh_dead    <= wdata[DTW-1:0];
                SEL_DUTY0: sh_duty[0] <= wdata;
                SEL_DUTY1: sh_duty[1] <= wdata;
                SEL_DUTY2: sh_duty[2] <= wdata;
                SEL_MODE:  sh_mode    <= wdata[1:0];
                SEL_SYNCW: sh_syncw   <= wdata[SWW-1:0];
                default:   ;
            endcase
        end
    end

    // Transfer shadows to the active set at the permitted update points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_half  <= CW'(DEF_HALF);
            act_dead  <= '0;
            act_duty  <= '0;
            act_mode  <= '0;
            act_syncw <= SWW'(1);
        end else if (load_all) begin
            act_half  <= sh_half;
            act_dead  <= sh_dead;
            act_duty  <= sh_duty;
            act_mode  <= sh_mode;
            act_syncw <= sh_syncw;
        end else if (load_duty) begin
            act_duty  <= sh_duty;
        end
    end
endmodule

// File: rtl/pwm3_timebase.sv
// pwm3_timebase: up/down period counter, external sync synchronizer and
// sync pulse stretcher. Assumes half >= 2, which the register block enforces.
module pwm3_timebase #(
    parameter int CW  = 10,
    parameter int SWW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  half,
    input  logic           dbl,
    input  logic           ext_en,
    input  logic [SWW-1:0] pulse_w,
    input  logic           ext_sync,
    output logic [CW-1:0]  cnt,
    output logic           second_half,
    output logic           start_evt,
    output logic           mid_evt,
    output logic           sync_out
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic           s1, s2, s3;
    logic           restart, at_top, at_end;
    logic [SWW-1:0] scnt;

    // Bring the asynchronous sync input into the clock domain and keep one
    // delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= ext_sync;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Decode the events that end a half or restart the period.
    always_comb begin
        restart   = ext_en && s2 && !s3;
        at_top    = !second_half && (cnt >= half - ONE);
        at_end    = second_half && (cnt <= ONE);
        start_evt = at_end || restart;
        mid_evt   = at_top && !restart;
    end

    // Triangular counter: up in the first half, down in the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '0;
            second_half <= 1'b0;
        end else if (start_evt) begin
            cnt         <= '0;
            second_half <= 1'b0;
        end else if (at_top) begin
            cnt         <= half;
            second_half <= 1'b1;
        end else if (second_half) begin
            cnt         <= cnt - ONE;
        end else begin
            cnt         <= cnt + ONE;
        end
    end

    // Stretch each sync event into a pulse of pulse_w cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scnt <= '0;
        else if (start_evt || (mid_evt && dbl))
            scnt <= pulse_w;
        else if (scnt != '0)
            scnt <= scnt - SWW'(1);
    end

    assign sync_out = (scnt != '0);
endmodule

// File: rtl/pwm3_phase.sv
// pwm3_phase: one inverter leg. Compares the counter with the clamped duty
// to form a centred pulse. Then it delays the rising edge of each side by
// the dead time. Assumes cnt never exceeds half.
module pwm3_phase #(
    parameter int CW  = 10,
    parameter int DTW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  cnt,
    input  logic           second_half,
    input  logic [CW-1:0]  half,
    input  logic [CW-1:0]  duty,
    input  logic [DTW-1:0] dead,
    output logic           hi,
    output logic           lo
);
    logic [CW-1:0]  thr;
    logic           raw_hi, raw_lo;
    logic [DTW-1:0] age_hi, age_lo;

    // Threshold from the clamped duty. The strict compare in the second half
    // keeps the pulse at exactly 2*duty cycles.
    always_comb begin
        thr    = half - ((duty > half) ? half : duty);
        raw_hi = second_half ? (cnt > thr) : (cnt >= thr);
        raw_lo = !raw_hi;
    end

    // Count how long each raw drive has been on, saturating at the dead time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_hi <= '0;
            age_lo <= '0;
        end else begin
            age_hi <= !raw_hi ? '0 : (age_hi >= dead) ? age_hi : age_hi + DTW'(1);
            age_lo <= !raw_lo ? '0 : (age_lo >= dead) ? age_lo : age_lo + DTW'(1);
        end
    end

    assign hi = raw_hi && (age_hi >= dead);
    assign lo = raw_lo && (age_lo >= dead);
endmodule

// File: rtl/pwm3_gen.sv
// pwm3_gen: top of the three-phase centre-aligned PWM generator. Ties the
// register block, the time base and three leg instances together.
// Assumes a single clock and a synchronous active-low reset.
module pwm3_gen
    import pwm3_pkg::*;
#(
    parameter int CW       = 10,
    parameter int DTW      = 6,
    parameter int SWW      = 6,
    parameter int DEF_HALF = 8,
    parameter int NPH      = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [2:0]     cfg_sel,
    input  logic [CW-1:0]  cfg_data,
    input  logic           ext_sync,
    output logic [2:0]     pwm_hi,
    output logic [2:0]     pwm_lo,
    output logic           sync_out,
    output logic           second_half
);
    logic [CW-1:0]      cnt, act_half;
    logic [DTW-1:0]     act_dead;
    logic [2:0][CW-1:0] act_duty;
    logic [1:0]         act_mode;
    logic [SWW-1:0]     act_syncw, sh_syncw, pulse_w;
    logic               start_evt, mid_evt, dbl;

    assign dbl     = act_mode[MODE_DBL_BIT];
    assign pulse_w = start_evt ? sh_syncw : act_syncw;

    pwm3_regs #(.CW(CW), .DTW(DTW), .SWW(SWW), .DEF_HALF(DEF_HALF)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_data),
        .load_all(start_evt), .load_duty(mid_evt && dbl),
        .act_half(act_half), .act_dead(act_dead), .act_duty(act_duty),
        .act_mode(act_mode), .act_syncw(act_syncw), .sh_syncw(sh_syncw)
    );

    pwm3_timebase #(.CW(CW), .SWW(SWW)) u_tb (
        .clk(clk), .rst_n(rst_n), .half(act_half), .dbl(dbl),
        .ext_en(act_mode[MODE_EXT_BIT]), .pulse_w(pulse_w), .ext_sync(ext_sync),
        .cnt(cnt), .second_half(second_half), .start_evt(start_evt),
        .mid_evt(mid_evt), .sync_out(sync_out)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_leg
        pwm3_phase #(.CW(CW), .DTW(DTW)) u_leg (
            .clk(clk), .rst_n(rst_n), .cnt(cnt), .second_half(second_half),
            .half(act_half), .duty(act_duty[i]), .dead(act_dead),
            .hi(pwm_hi[i]), .lo(pwm_lo[i])
        );
    end
endmodule

// File: rtl/pwm3_gen_chk.sv
// pwm3_gen_chk: cycle-by-cycle properties of pwm3_gen, attached by bind.
// Assumes the top's internal names cnt, act_half, act_dead and act_mode.
module pwm3_gen_chk #(
    parameter int CW  = 10,
    parameter int DTW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic [2:0]     pwm_hi,
    input logic [2:0]     pwm_lo,
    input logic           sync_out,
    input logic           second_half,
    input logic [CW-1:0]  cnt,
    input logic [CW-1:0]  act_half,
    input logic [DTW-1:0] act_dead,
    input logic [1:0]     act_mode
);
    p_first_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !second_half |-> cnt < act_half);
    p_second_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        second_half |-> (cnt >= CW'(1) && cnt <= act_half));
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_mode[1] && second_half && cnt == CW'(1)) |=> (!second_half && cnt == '0));
    p_turn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_mode[1] && !second_half && cnt == act_half - CW'(1)) |=>
        (second_half && cnt == $past(act_half)));
    p_sync_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |-> (cnt == '0 || cnt == act_half));

    for (genvar i = 0; i < 3; i++) begin : g_pair
        p_pair_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(pwm_hi[i] && pwm_lo[i]));
        p_gap_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (act_dead != '0 && $stable(act_dead) && $rose(pwm_hi[i])) |-> !$past(pwm_lo[i]));
        p_gap_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (act_dead != '0 && $stable(act_dead) && $rose(pwm_lo[i])) |-> !$past(pwm_hi[i]));
    end
endmodule

bind pwm3_gen pwm3_gen_chk #(.CW(CW), .DTW(DTW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .sync_out(sync_out), .second_half(second_half), .cnt(cnt),
    .act_half(act_half), .act_dead(act_dead), .act_mode(act_mode)
);

// File: tb/pwm3_gen_bench.sv
// pwm3_gen_bench: vector table of duty/dead-time cases, then directed tests.
module pwm3_gen_bench;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [CW-1:0] cfg_data = '0;
    logic          ext_sync = 1'b0;
    logic [2:0]    pwm_hi, pwm_lo;
    logic          sync_out, second_half;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pwm3_gen u_pwm3_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .ext_sync(ext_sync), .pwm_hi(pwm_hi),
        .pwm_lo(pwm_lo), .sync_out(sync_out), .second_half(second_half)
    );

    typedef struct packed {
        int half; int duty; int dead; int hi; int lo;
    } vec_t;
    // hi = 2*min(duty,half) - dead (or 0 / 2*half); lo = remainder - dead
    localparam vec_t VT [7] = '{
        '{8, 3, 0, 6, 10},
        '{8, 3, 2, 4, 8},
        '{8, 0, 1, 0, 16},
        '{8, 8, 1, 16, 0},
        '{8, 12, 0, 16, 0},
        '{20, 5, 3, 7, 27},
        '{4, 1, 0, 2, 6}
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_data = CW'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Leaves the bench at the negedge of the cycle with counter 0.
    task automatic wait_start();
        do @(negedge clk); while (!second_half);
        do @(negedge clk); while (second_half);
    endtask

    task automatic settle();
        wait_start(); wait_start();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int h0, l0, h2, ov, a, b, n;
        repeat (3) @(negedge clk);
        // Reset state
        chk("R1 reset second_half", int'(second_half), 0);
        chk("R2 reset hi", int'(pwm_hi), 0);
        chk("R6 reset sync", int'(sync_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset lo (duty 0, dead 0)", int'(pwm_lo), 7);

        // Vector walk: R2, R3 pulse widths, R10 select codes
        foreach (VT[k]) begin
            wr(0, VT[k].half); wr(1, VT[k].dead); wr(2, VT[k].duty); wr(4, VT[k].duty);
            settle();
            h0 = 0; l0 = 0; h2 = 0; ov = 0;
            for (int c = 0; c < 2 * VT[k].half; c++) begin
                h0 += int'(pwm_hi[0]); l0 += int'(pwm_lo[0]); h2 += int'(pwm_hi[2]);
                ov += int'(pwm_hi[0] && pwm_lo[0]);
                @(negedge clk);
            end
            chk($sformatf("R2 vec%0d hi0", k), h0, VT[k].hi);
            chk($sformatf("R3 vec%0d lo0", k), l0, VT[k].lo);
            chk($sformatf("R2 vec%0d hi2", k), h2, VT[k].hi);
            chk($sformatf("R3 vec%0d overlap", k), ov, 0);
        end

        // R1: half lengths with H=8
        wr(0, 8); wr(1, 0); wr(2, 3); wr(4, 0);
        settle();
        a = 0; b = 0;
        for (int c = 0; c < 16; c++) begin
            if (second_half) b++; else a++;
            @(negedge clk);
        end
        chk("R1 first half length", a, 8);
        chk("R1 second half length", b, 8);

        // R4: write during second half does not alter it
        do @(negedge clk); while (!second_half);
        cfg_we = 1'b1; cfg_sel = 3'd2; cfg_data = CW'(7);
        a = 0;
        for (int c = 0; c < 8; c++) begin
            a += int'(pwm_hi[0]);
            @(negedge clk);
            cfg_we = 1'b0;
        end
        chk("R4 rest of period keeps old duty", a, 3);
        a = 0;
        for (int c = 0; c < 16; c++) begin a += int'(pwm_hi[0]); @(negedge clk); end
        chk("R4 next period uses new duty", a, 14);

        // R5: midpoint reload (double) against single mode
        for (int m = 0; m < 2; m++) begin
            wr(5, m); wr(2, 2);
            settle();
            cfg_we = 1'b1; cfg_sel = 3'd2; cfg_data = CW'(6);
            a = 0; b = 0;
            for (int c = 0; c < 16; c++) begin
                if (c < 8) a += int'(pwm_hi[0]); else b += int'(pwm_hi[0]);
                @(negedge clk);
                cfg_we = 1'b0;
            end
            chk($sformatf("R5 mode%0d first half", m), a, 2);
            chk($sformatf("R5 mode%0d second half", m), b, (m == 1) ? 6 : 2);
        end

        // R6, R7: sync widths
        for (int m = 0; m < 2; m++) begin
            wr(5, m); wr(6, 3);
            settle();
            chk($sformatf("R6 mode%0d sync at start", m), int'(sync_out), 1);
            a = 0;
            for (int c = 0; c < 16; c++) begin a += int'(sync_out); @(negedge clk); end
            chk($sformatf("R7 mode%0d sync cycles", m), a, (m == 1) ? 6 : 3);
        end
        wr(5, 0); wr(6, 0);
        settle();
        a = 0;
        for (int c = 0; c < 16; c++) begin a += int'(sync_out); @(negedge clk); end
        chk("R6 width 0 no pulse", a, 0);

        // R8: external restart, enabled then disabled
        wr(6, 1);
        for (int m = 0; m < 2; m++) begin
            wr(5, (m == 0) ? 2 : 0);
            settle();
            repeat (3) @(negedge clk);
            ext_sync = 1'b1;
            @(negedge clk);
            chk($sformatf("R8 en%0d no sync +1", m), int'(sync_out), 0);
            @(negedge clk);
            chk($sformatf("R8 en%0d no sync +2", m), int'(sync_out), 0);
            @(negedge clk);
            chk($sformatf("R8 en%0d sync +3", m), int'(sync_out), (m == 0) ? 1 : 0);
            ext_sync = 1'b0;
            if (m == 0) begin
                repeat (15) @(negedge clk);
                chk("R8 restarted period no early sync", int'(sync_out), 0);
                @(negedge clk);
                chk("R8 restarted period full length", int'(sync_out), 1);
            end
        end

        // R9: half-period below 2 clamps to 2 (period of 4)
        wr(0, 1);
        settle();
        n = 0;
        do begin @(negedge clk); n++; end while (!second_half);
        do begin @(negedge clk); n++; end while (second_half);
        chk("R9 clamped period", n, 4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule